// File: doc/BRIEF.md
# Power-Up Boot Loader and Memory Clearer

After an active-low reset is released, this block walks one fixed sequence that puts the memories and control state of a signal-processing core into a known condition. It copies the boot image of the program RAM and of the coefficient RAM from constant on-chip ROMs. It clears every word of the data RAM and every host control register. A single cycle counter supplies the one address that all three RAMs share. The sequence always lasts 2^CNT_W master-clock cycles, which is 1024 with the defaults. The length is counted in clock edges, so it does not depend on the clock frequency.

While the sequence runs, the block raises `busy`. It discards any host register write that arrives in that time and records each such write in a sticky error flag. A one-cycle `done` pulse marks the end. After that, host writes take effect and the RAM contents can be read through the read ports that the core uses. A new reset in the middle of the sequence aborts it. The next release starts the sequence again from address 0.

Top module: `init_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs after that edge are `busy`=1, `done`=0 and `wr_err`=0, and the host registers read as 0.
- R2: After `rst_n` rises, `busy` stays high for exactly 2^CNT_W clock edges (1024 with the defaults) and then goes low.
- R3: `done` is high for exactly one cycle. That cycle is the first one in which `busy` is low after the sequence.
- R4: When the sequence finishes, the program RAM word at address a equals bits [PROG_DW-1:0] of (a * 0x19E37) XOR 0xA5C3F0, computed in 32 bits.
- R5: When the sequence finishes, the coefficient RAM word at address a equals bits [COEF_DW-1:0] of a * 0x101 + 0x1234, computed in 32 bits.
- R6: When the sequence finishes, every data RAM word reads 0.
- R7: When the sequence finishes, every host control register reads 0, even if it held a value before the reset.
- R8: A host write at a clock edge at which `busy` is high, including the last busy edge, leaves the registers unchanged and sets `wr_err` from the next cycle on.
- R9: `wr_err` stays set until the next reset. A host write at an edge where `busy` is low is stored. It can be read back on `host_rd_data` one edge after `host_rd_addr` selects it.
- R10: Asserting reset part-way through the sequence aborts it. After the next release, a full sequence of 2^CNT_W edges runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; the sequence length is counted in its cycles |
| rst_n | input | 1 | Synchronous active-low reset; the sequence starts when it is released |
| host_wr_en | input | 1 | Host register write strobe |
| host_wr_addr | input | REG_AW | Host register write address |
| host_wr_data | input | REG_DW | Host register write data |
| host_rd_addr | input | REG_AW | Host register read address |
| host_rd_data | output | REG_DW | Registered host register read data |
| prog_rd_addr | input | PROG_AW | Program RAM read address |
| prog_rd_data | output | PROG_DW | Registered program RAM read data |
| coef_rd_addr | input | COEF_AW | Coefficient RAM read address |
| coef_rd_data | output | COEF_DW | Registered coefficient RAM read data |
| data_rd_addr | input | DATA_AW | Data RAM read address |
| data_rd_data | output | DATA_DW | Registered data RAM read data |
| busy | output | 1 | High during reset and during the initialization sequence |
| done | output | 1 | One-cycle pulse when the sequence ends |
| wr_err | output | 1 | Sticky flag: a host write was dropped while busy |

## Verification
Two events can meet in the same cycle: the end of the sequence and the first host write. The bench places a host write exactly on the last busy edge. It expects that write to be dropped and flagged, with `done` rising in the same cycle. A second write goes in the `done` cycle itself, and the bench expects it to be stored. Reading both registers back afterwards tells the two outcomes apart.

// File: rtl/init_seq_pkg.sv
package init_seq_pkg;

  typedef enum logic [1:0] {
    FILL_PROG = 2'd0,
    FILL_COEF = 2'd1,
    FILL_ZERO = 2'd2
  } fill_kind_e;

  // Boot image of the program store, generated from the address.
  function automatic logic [31:0] prog_boot_word(input logic [31:0] a);
    return (a * 32'h0001_9E37) ^ 32'h00A5_C3F0;
  endfunction

  // Boot image of the coefficient store.
  function automatic logic [31:0] coef_boot_word(input logic [31:0] a);
    return (a * 32'h0000_0101) + 32'h0000_1234;
  endfunction

endpackage

// File: rtl/init_counter.sv
module init_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt,
  output logic             busy,
  output logic             done
);

  localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b1;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/boot_ram.sv
module boot_ram
  import init_seq_pkg::*;
#(
  parameter int         AW    = 10,
  parameter int         DW    = 24,
  parameter int         CNT_W = 10,
  parameter fill_kind_e KIND  = FILL_ZERO
) (
  input  logic             clk,
  input  logic             fill_we,
  input  logic [CNT_W-1:0] fill_cnt,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] fill_addr;
  logic [DW-1:0] fill_word;

  assign fill_addr = AW'(fill_cnt);

  generate
    if (KIND == FILL_PROG) begin : g_prog
      assign fill_word = DW'(prog_boot_word(32'(fill_addr)));
    end else if (KIND == FILL_COEF) begin : g_coef
      assign fill_word = DW'(coef_boot_word(32'(fill_addr)));
    end else begin : g_zero
      assign fill_word = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (fill_we) mem[fill_addr] <= fill_word;
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/ctrl_regfile.sv
module ctrl_regfile #(
  parameter int REG_AW = 4,
  parameter int REG_DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [REG_DW-1:0] wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [REG_DW-1:0] rd_data,
  output logic              wr_err
);

  localparam int NREG = 1 << REG_AW;

  logic [REG_DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_err  <= 1'b0;
      rd_data <= '0;
    end else begin
      if (wr_en && clear) wr_err <= 1'b1;
      rd_data <= regs[rd_addr];
    end
  end

endmodule

// File: rtl/init_sequencer.sv
module init_sequencer
  import init_seq_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int PROG_AW = 10,
  parameter int PROG_DW = 24,
  parameter int COEF_AW = 8,
  parameter int COEF_DW = 16,
  parameter int DATA_AW = 9,
  parameter int DATA_DW = 24,
  parameter int REG_AW  = 4,
  parameter int REG_DW  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr_en,
  input  logic [REG_AW-1:0]  host_wr_addr,
  input  logic [REG_DW-1:0]  host_wr_data,
  input  logic [REG_AW-1:0]  host_rd_addr,
  output logic [REG_DW-1:0]  host_rd_data,
  input  logic [PROG_AW-1:0] prog_rd_addr,
  output logic [PROG_DW-1:0] prog_rd_data,
  input  logic [COEF_AW-1:0] coef_rd_addr,
  output logic [COEF_DW-1:0] coef_rd_data,
  input  logic [DATA_AW-1:0] data_rd_addr,
  output logic [DATA_DW-1:0] data_rd_data,
  output logic               busy,
  output logic               done,
  output logic               wr_err
);

  logic [CNT_W-1:0] seq_cnt;
  logic             fill_we;

  init_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .cnt  (seq_cnt),
    .busy (busy),
    .done (done)
  );

  assign fill_we = busy && rst_n;

  boot_ram #(.AW(PROG_AW), .DW(PROG_DW), .CNT_W(CNT_W), .KIND(FILL_PROG)) u_prog (
    .clk(clk), .fill_we(fill_we), .fill_cnt(seq_cnt),
    .rd_addr(prog_rd_addr), .rd_data(prog_rd_data)
  );

  boot_ram #(.AW(COEF_AW), .DW(COEF_DW), .CNT_W(CNT_W), .KIND(FILL_COEF)) u_coef (
    .clk(clk), .fill_we(fill_we), .fill_cnt(seq_cnt),
    .rd_addr(coef_rd_addr), .rd_data(coef_rd_data)
  );

  boot_ram #(.AW(DATA_AW), .DW(DATA_DW), .CNT_W(CNT_W), .KIND(FILL_ZERO)) u_data (
    .clk(clk), .fill_we(fill_we), .fill_cnt(seq_cnt),
    .rd_addr(data_rd_addr), .rd_data(data_rd_data)
  );

  ctrl_regfile #(.REG_AW(REG_AW), .REG_DW(REG_DW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (busy),
    .wr_en  (host_wr_en),
    .wr_addr(host_wr_addr),
    .wr_data(host_wr_data),
    .rd_addr(host_rd_addr),
    .rd_data(host_rd_data),
    .wr_err (wr_err)
  );

endmodule

// File: rtl/init_sequencer_chk.sv
module init_sequencer_chk #(
  parameter int CNT_W = 10
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic wr_err,
  input logic host_wr_en
);

  localparam logic [CNT_W:0] FULL_LEN = (CNT_W+1)'(1) << CNT_W;

  logic [CNT_W:0] run_len;

  always_ff @(posedge clk) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (busy && !done && !wr_err));

  // R2
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == FULL_LEN));

  // R10
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_len < FULL_LEN));

  // R3
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy ##1 !done));

  // R8
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_wr_en) |=> wr_err);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> wr_err);

endmodule

bind init_sequencer init_sequencer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .wr_err    (wr_err),
  .host_wr_en(host_wr_en)
);

// File: tb/tb_init_sequencer.sv
module tb_init_sequencer;

  localparam int CYC = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_en = 1'b0;
  logic [3:0]  host_wr_addr = '0;
  logic [15:0] host_wr_data = '0;
  logic [3:0]  host_rd_addr = '0;
  logic [15:0] host_rd_data;
  logic [9:0]  prog_rd_addr = '0;
  logic [23:0] prog_rd_data;
  logic [7:0]  coef_rd_addr = '0;
  logic [15:0] coef_rd_data;
  logic [8:0]  data_rd_addr = '0;
  logic [23:0] data_rd_data;
  logic        busy, done, wr_err;

  int nvec = 0;
  int nbad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  init_sequencer dut (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
    .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data),
    .prog_rd_addr(prog_rd_addr), .prog_rd_data(prog_rd_data),
    .coef_rd_addr(coef_rd_addr), .coef_rd_data(coef_rd_data),
    .data_rd_addr(data_rd_addr), .data_rd_data(data_rd_data),
    .busy(busy), .done(done), .wr_err(wr_err)
  );

  // {kind, address}: kind 0 program, 1 coefficient, 2 data
  localparam logic [11:0] VEC [10] = '{
    {2'd0, 10'd0}, {2'd0, 10'd1}, {2'd0, 10'd511}, {2'd0, 10'd1023},
    {2'd1, 10'd0}, {2'd1, 10'd77}, {2'd1, 10'd255},
    {2'd2, 10'd0}, {2'd2, 10'd300}, {2'd2, 10'd511}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_boot(output int n);
    n = 0;
    while (busy && n < 3000) begin
      tick();
      n++;
    end
  endtask

  task automatic read_reg(input logic [3:0] a, output logic [15:0] v);
    host_rd_addr = a;
    tick();
    v = host_rd_data;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    int n;
    int m;
    logic [15:0] rv;
    logic [31:0] exp;

    // reset state
    repeat (3) tick();
    check("R1 busy", 32'(busy), 1);
    check("R1 done", 32'(done), 0);
    check("R1 wr_err", 32'(wr_err), 0);
    read_reg(4'd3, rv);
    check("R1 reg", 32'(rv), 0);

    // run 1: write while busy in the middle
    rst_n = 1'b1;
    repeat (500) tick();
    host_wr_en = 1'b1; host_wr_addr = 4'd3; host_wr_data = 16'hA5A5;
    tick();
    host_wr_en = 1'b0;
    run_boot(m);
    check("R2 length", 32'(501 + m), CYC);
    check("R3 done rise", 32'(done), 1);
    tick();
    check("R3 done one cycle", 32'(done), 0);
    check("R8 err set", 32'(wr_err), 1);
    read_reg(4'd3, rv);
    check("R8 write dropped", 32'(rv), 0);

    // memory contents, table driven
    for (int i = 0; i < 10; i++) begin
      prog_rd_addr = VEC[i][9:0];
      coef_rd_addr = VEC[i][7:0];
      data_rd_addr = VEC[i][8:0];
      tick();
      case (VEC[i][11:10])
        2'd0: begin
          exp = (32'(VEC[i][9:0]) * 32'h0001_9E37) ^ 32'h00A5_C3F0;
          check("R4 prog word", 32'(prog_rd_data), {8'h0, exp[23:0]});
        end
        2'd1: begin
          exp = (32'(VEC[i][7:0]) * 32'h0000_0101) + 32'h0000_1234;
          check("R5 coef word", 32'(coef_rd_data), {16'h0, exp[15:0]});
        end
        default: check("R6 data zero", 32'(data_rd_data), 0);
      endcase
    end

    // writes after done are accepted, error stays
    host_wr_en = 1'b1; host_wr_addr = 4'd3; host_wr_data = 16'hBEEF;
    tick();
    host_wr_en = 1'b0;
    read_reg(4'd3, rv);
    check("R9 write stored", 32'(rv), 32'h0000_BEEF);
    check("R9 err sticky", 32'(wr_err), 1);

    // run 2: abort mid-sequence
    rst_n = 1'b0;
    tick(); tick();
    check("R1 err cleared", 32'(wr_err), 0);
    rst_n = 1'b1;
    repeat (300) tick();
    check("R10 busy mid", 32'(busy), 1);
    rst_n = 1'b0;
    tick(); tick();
    check("R10 busy in reset", 32'(busy), 1);
    check("R10 no done", 32'(done), 0);
    rst_n = 1'b1;
    run_boot(n);
    check("R10 full restart length", 32'(n), CYC);
    read_reg(4'd3, rv);
    check("R7 reg cleared", 32'(rv), 0);
    prog_rd_addr = 10'd700;
    tick();
    exp = (32'd700 * 32'h0001_9E37) ^ 32'h00A5_C3F0;
    check("R4 prog after restart", 32'(prog_rd_data), {8'h0, exp[23:0]});

    // run 3: write on last busy edge, then on done cycle
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    repeat (CYC - 1) tick();
    check("R2 busy before last edge", 32'(busy), 1);
    host_wr_en = 1'b1; host_wr_addr = 4'd5; host_wr_data = 16'h1111;
    tick();
    check("R2 busy low", 32'(busy), 0);
    check("R3 done", 32'(done), 1);
    check("R8 err on last edge", 32'(wr_err), 1);
    host_wr_addr = 4'd6; host_wr_data = 16'h2222;
    tick();
    host_wr_en = 1'b0;
    check("R3 done low", 32'(done), 0);
    read_reg(4'd5, rv);
    check("R8 last-edge write dropped", 32'(rv), 0);
    read_reg(4'd6, rv);
    check("R9 done-cycle write stored", 32'(rv), 32'h0000_2222);

    finish_run();
  end

endmodule